// File: doc/BRIEF.md
# Mode-Banked Register File

This block stores the integer registers of a 32-bit processor core that runs in one of seven operating modes. Software sees sixteen architectural registers, indexed 0 to 15. Which physical storage cell an index reaches depends on the current mode.

The fast-interrupt mode has its own copies of indices 8 to 14. The four other exception modes each have their own copies of indices 13 (stack pointer) and 14 (link register) only. Index 15, the program counter, is a single cell that every mode shares. Each of the five exception modes also owns one saved-status register. The user and system modes own none.

The core reads two registers at a time and writes one. A separate port reads and writes the saved-status register of the current mode. A dedicated load path updates the program counter. A second, banked port names its mode explicitly, so an exception-entry sequencer can fill in the link register and saved status of the mode it is about to enter while the core is still in the old mode. Mode codes that name no mode are flagged and made harmless.

Top module: `rbank_regfile`

## Requirements
- R1: The mode code is decoded as follows:
  - 10000 = user
  - 10001 = fast interrupt
  - 10010 = interrupt
  - 10011 = supervisor
  - 10111 = abort
  - 11011 = undefined
  - 11111 = system

  Any other code drives `illegal_o` high in the same cycle. A valid code drives it low.
- R2: User and system modes see one identical set of sixteen registers. In either mode `sr_rd_data` reads zero, and a saved-status write changes no stored state.
- R3: In fast-interrupt mode, indices 8 to 14 reach private copies. Indices 0 to 7 reach the same cells as in user mode.
- R4: In interrupt, supervisor, abort and undefined mode, indices 13 and 14 reach copies private to that mode. Indices 0 to 12 reach the user cells.
- R5: Index 15 is one cell shared by all modes and is visible on `pc_o`. When `pc_ld_en` is high, `pc_ld_data` is stored at the rising edge, and it wins over any write to index 15 made in the same cycle.
- R6: There are five saved-status registers, one for each exception mode. `sr_rd_data` and `sr_wr_en` address the one that belongs to the current mode.
- R7: While the mode code is invalid, writes through the general port and the saved-status port are dropped, and `rd_a_data`, `rd_b_data` and `sr_rd_data` read zero.
- R8: Reads are combinational. Writes take effect at the rising clock edge. A read of a register that is being written in the same cycle returns the value held before that edge.
- R9: The banked port reads and writes the registers and the saved status of `bk_mode`, independent of `mode_i`. The R1, R2 and R7 rules apply to `bk_mode`. When the banked port and the general port write the same physical cell in one cycle, the banked value is stored.
- R10: After reset, every register and every saved-status register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Current mode code |
| illegal_o | output | 1 | Current mode code is invalid |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | DW | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | General write index |
| wr_data | input | DW | General write data |
| sr_rd_data | output | DW | Saved status of the current mode |
| sr_wr_en | input | 1 | Saved-status write enable, current mode |
| sr_wr_data | input | DW | Saved-status write data |
| pc_ld_en | input | 1 | Program counter load enable |
| pc_ld_data | input | DW | Program counter load value |
| pc_o | output | DW | Program counter value |
| bk_mode | input | 5 | Mode addressed by the banked port |
| bk_idx | input | 4 | Banked port index |
| bk_rd_data | output | DW | Banked port read data |
| bk_wr_en | input | 1 | Banked port write enable |
| bk_wr_data | input | DW | Banked port write data |
| bk_sr_rd_data | output | DW | Saved status of `bk_mode` |
| bk_sr_wr_en | input | 1 | Banked saved-status write enable |
| bk_sr_wr_data | input | DW | Banked saved-status write data |

## Verification
The bench writes distinct values through every mode and reads them back through other modes. A mapping that put the fast-interrupt copies on the wrong indices, or let one exception mode share another's stack pointer, would therefore return a neighbour's value.

It also covers these corner cases:
- Writes from an invalid mode code and saved-status writes from the user mode. A design that did not gate these would corrupt cells seen later from valid modes.
- A write and a read of the same register in one cycle. This exposes a bypass that returns the new value too early.
- Same-cycle clashes between the load path and a write to index 15, and between the banked and general ports. A wrong priority stores the losing value.

// File: rtl/rbank_pkg.sv
package rbank_pkg;

   localparam int unsigned NUM_ARCH  = 16;
   localparam int unsigned IDX_W     = 4;
   localparam int unsigned MODE_W    = 5;
   localparam int unsigned PC_IDX    = NUM_ARCH - 1;
   localparam int unsigned FIQ_FIRST = 8;
   localparam int unsigned FIQ_PRIV  = PC_IDX - FIQ_FIRST;
   localparam int unsigned SML_FIRST = 13;
   localparam int unsigned SML_PRIV  = PC_IDX - SML_FIRST;
   localparam int unsigned NUM_SML   = 4;
   localparam int unsigned NUM_SAVED = NUM_SML + 1;
   localparam int unsigned NUM_GPR   = NUM_ARCH + FIQ_PRIV + NUM_SML * SML_PRIV;
   localparam int unsigned PHYS_W    = $clog2(NUM_GPR);
   localparam int unsigned SLOT_W    = $clog2(NUM_SAVED);

   localparam logic [MODE_W-1:0] MC_USR = 5'b10000;
   localparam logic [MODE_W-1:0] MC_FIQ = 5'b10001;
   localparam logic [MODE_W-1:0] MC_IRQ = 5'b10010;
   localparam logic [MODE_W-1:0] MC_SVC = 5'b10011;
   localparam logic [MODE_W-1:0] MC_ABT = 5'b10111;
   localparam logic [MODE_W-1:0] MC_UND = 5'b11011;
   localparam logic [MODE_W-1:0] MC_SYS = 5'b11111;

   typedef enum logic [2:0] {
      BK_USR = 3'd0,
      BK_FIQ = 3'd1,
      BK_IRQ = 3'd2,
      BK_SVC = 3'd3,
      BK_ABT = 3'd4,
      BK_UND = 3'd5,
      BK_BAD = 3'd6
   } bank_e;

   function automatic logic bank_saved(bank_e b);
      return b inside {BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND};
   endfunction

endpackage

// File: rtl/rbank_mode_decode.sv
module rbank_mode_decode
   import rbank_pkg::*;
(
   input  logic [MODE_W-1:0] code_i,
   output bank_e             bank_o,
   output logic              bad_o
);

   always_comb begin
      unique case (code_i)
         MC_USR, MC_SYS: bank_o = BK_USR;
         MC_FIQ:         bank_o = BK_FIQ;
         MC_IRQ:         bank_o = BK_IRQ;
         MC_SVC:         bank_o = BK_SVC;
         MC_ABT:         bank_o = BK_ABT;
         MC_UND:         bank_o = BK_UND;
         default:        bank_o = BK_BAD;
      endcase
   end

   assign bad_o = (bank_o == BK_BAD);

endmodule

// File: rtl/rbank_index_map.sv
module rbank_index_map
   import rbank_pkg::*;
(
   input  bank_e             bank_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [PHYS_W-1:0] phys_o
);

   always_comb begin
      int unsigned i;
      int unsigned p;
      int unsigned off;
      i   = 32'(idx_i);
      off = 32'(bank_i) - 32'(BK_IRQ);
      p   = i;
      if (i != PC_IDX) begin
         if (bank_i == BK_FIQ && i >= FIQ_FIRST)
            p = NUM_ARCH + i - FIQ_FIRST;
         else if (bank_i inside {BK_IRQ, BK_SVC, BK_ABT, BK_UND} && i >= SML_FIRST)
            p = NUM_ARCH + FIQ_PRIV + off * SML_PRIV + i - SML_FIRST;
      end
      phys_o = PHYS_W'(p);
   end

endmodule

// File: rtl/rbank_storage.sv
module rbank_storage
   import rbank_pkg::*;
#(
   parameter int unsigned DW     = 32,
   parameter int unsigned NRD    = 3,
   parameter int unsigned NSRRD  = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PHYS_W-1:0] rd_phys [NRD],
   output logic [DW-1:0]     rd_data [NRD],
   input  logic              wr_lo_en,
   input  logic [PHYS_W-1:0] wr_lo_phys,
   input  logic [DW-1:0]     wr_lo_data,
   input  logic              wr_hi_en,
   input  logic [PHYS_W-1:0] wr_hi_phys,
   input  logic [DW-1:0]     wr_hi_data,
   input  logic              pc_ld_en,
   input  logic [DW-1:0]     pc_ld_data,
   output logic [DW-1:0]     pc_q,
   input  logic [SLOT_W-1:0] sr_rd_slot [NSRRD],
   output logic [DW-1:0]     sr_rd_data [NSRRD],
   input  logic              sr_lo_en,
   input  logic [SLOT_W-1:0] sr_lo_slot,
   input  logic [DW-1:0]     sr_lo_data,
   input  logic              sr_hi_en,
   input  logic [SLOT_W-1:0] sr_hi_slot,
   input  logic [DW-1:0]     sr_hi_data
);

   logic [NUM_GPR-1:0][DW-1:0]   regs_flat;
   logic [NUM_SAVED-1:0][DW-1:0] sr_flat;

   for (genvar g = 0; g < NUM_GPR; g++) begin : g_reg
      logic          hit_lo, hit_hi;
      logic [DW-1:0] cell_q;
      assign hit_lo = wr_lo_en && (wr_lo_phys == PHYS_W'(g));
      assign hit_hi = wr_hi_en && (wr_hi_phys == PHYS_W'(g));
      if (g == PC_IDX) begin : g_pc
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cell_q <= '0;
            else if (pc_ld_en) cell_q <= pc_ld_data;
            else if (hit_hi)   cell_q <= wr_hi_data;
            else if (hit_lo)   cell_q <= wr_lo_data;
         end
      end else begin : g_gp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cell_q <= '0;
            else if (hit_hi) cell_q <= wr_hi_data;
            else if (hit_lo) cell_q <= wr_lo_data;
         end
      end
      assign regs_flat[g] = cell_q;
   end

   for (genvar s = 0; s < NUM_SAVED; s++) begin : g_sr
      logic [DW-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q <= '0;
         else if (sr_hi_en && sr_hi_slot == SLOT_W'(s))
            cell_q <= sr_hi_data;
         else if (sr_lo_en && sr_lo_slot == SLOT_W'(s))
            cell_q <= sr_lo_data;
      end
      assign sr_flat[s] = cell_q;
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rd_data[r] = regs_flat[rd_phys[r]];
   end

   for (genvar r = 0; r < NSRRD; r++) begin : g_srrd
      assign sr_rd_data[r] = sr_flat[sr_rd_slot[r]];
   end

   assign pc_q = regs_flat[PC_IDX];

   // R8
   wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo_en && !(wr_hi_en && wr_hi_phys == wr_lo_phys)
                && !(pc_ld_en && wr_lo_phys == PHYS_W'(PC_IDX)))
      |=> regs_flat[$past(wr_lo_phys)] == $past(wr_lo_data));

   // R5
   pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_ld_en |=> pc_q == $past(pc_ld_data));

   // R7
   gpr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_lo_en && !wr_hi_en && !pc_ld_en) |=> $stable(regs_flat));

   // R2
   sr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_lo_en && !sr_hi_en) |=> $stable(sr_flat));

endmodule

// File: rtl/rbank_regfile.sv
module rbank_regfile
   import rbank_pkg::*;
#(
   parameter int unsigned DW = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        mode_i,
   output logic              illegal_o,
   input  logic [3:0]        rd_a_idx,
   output logic [DW-1:0]     rd_a_data,
   input  logic [3:0]        rd_b_idx,
   output logic [DW-1:0]     rd_b_data,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic [DW-1:0]     wr_data,
   output logic [DW-1:0]     sr_rd_data,
   input  logic              sr_wr_en,
   input  logic [DW-1:0]     sr_wr_data,
   input  logic              pc_ld_en,
   input  logic [DW-1:0]     pc_ld_data,
   output logic [DW-1:0]     pc_o,
   input  logic [4:0]        bk_mode,
   input  logic [3:0]        bk_idx,
   output logic [DW-1:0]     bk_rd_data,
   input  logic              bk_wr_en,
   input  logic [DW-1:0]     bk_wr_data,
   output logic [DW-1:0]     bk_sr_rd_data,
   input  logic              bk_sr_wr_en,
   input  logic [DW-1:0]     bk_sr_wr_data
);

   localparam int unsigned NMAP = 4;

   if (DW < 8) begin : g_dw_chk
      $error("rbank_regfile: DW must be at least 8");
   end
   if (MODE_W != 5 || IDX_W != 4) begin : g_fmt_chk
      $error("rbank_regfile: port widths disagree with package");
   end

   bank_e cur_bank, alt_bank;
   logic  cur_bad, alt_bad;

   rbank_mode_decode u_cur_dec (.code_i(mode_i),  .bank_o(cur_bank), .bad_o(cur_bad));
   rbank_mode_decode u_alt_dec (.code_i(bk_mode), .bank_o(alt_bank), .bad_o(alt_bad));

   // map slots: 0 read A, 1 read B, 2 general write, 3 banked port
   bank_e             map_bank [NMAP];
   logic [IDX_W-1:0]  map_idx  [NMAP];
   logic [PHYS_W-1:0] map_phys [NMAP];

   assign map_bank[0] = cur_bank;  assign map_idx[0] = rd_a_idx;
   assign map_bank[1] = cur_bank;  assign map_idx[1] = rd_b_idx;
   assign map_bank[2] = cur_bank;  assign map_idx[2] = wr_idx;
   assign map_bank[3] = alt_bank;  assign map_idx[3] = bk_idx;

   for (genvar m = 0; m < NMAP; m++) begin : g_map
      rbank_index_map u_map (
         .bank_i(map_bank[m]),
         .idx_i (map_idx[m]),
         .phys_o(map_phys[m])
      );
   end

   logic              cur_sv, alt_sv;
   logic [SLOT_W-1:0] cur_slot, alt_slot;
   assign cur_sv   = bank_saved(cur_bank);
   assign alt_sv   = bank_saved(alt_bank);
   assign cur_slot = cur_sv ? SLOT_W'(32'(cur_bank) - 1) : '0;
   assign alt_slot = alt_sv ? SLOT_W'(32'(alt_bank) - 1) : '0;

   logic [PHYS_W-1:0] rd_phys [3];
   logic [DW-1:0]     rd_raw  [3];
   logic [SLOT_W-1:0] sr_slot [2];
   logic [DW-1:0]     sr_raw  [2];

   assign rd_phys[0] = map_phys[0];
   assign rd_phys[1] = map_phys[1];
   assign rd_phys[2] = map_phys[3];
   assign sr_slot[0] = cur_slot;
   assign sr_slot[1] = alt_slot;

   rbank_storage #(.DW(DW), .NRD(3), .NSRRD(2)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_phys   (rd_phys),
      .rd_data   (rd_raw),
      .wr_lo_en  (wr_en && !cur_bad),
      .wr_lo_phys(map_phys[2]),
      .wr_lo_data(wr_data),
      .wr_hi_en  (bk_wr_en && !alt_bad),
      .wr_hi_phys(map_phys[3]),
      .wr_hi_data(bk_wr_data),
      .pc_ld_en  (pc_ld_en),
      .pc_ld_data(pc_ld_data),
      .pc_q      (pc_o),
      .sr_rd_slot(sr_slot),
      .sr_rd_data(sr_raw),
      .sr_lo_en  (sr_wr_en && cur_sv),
      .sr_lo_slot(cur_slot),
      .sr_lo_data(sr_wr_data),
      .sr_hi_en  (bk_sr_wr_en && alt_sv),
      .sr_hi_slot(alt_slot),
      .sr_hi_data(bk_sr_wr_data)
   );

   assign illegal_o     = cur_bad;
   assign rd_a_data     = cur_bad ? '0 : rd_raw[0];
   assign rd_b_data     = cur_bad ? '0 : rd_raw[1];
   assign bk_rd_data    = alt_bad ? '0 : rd_raw[2];
   assign sr_rd_data    = cur_sv  ? sr_raw[0] : '0;
   assign bk_sr_rd_data = alt_sv  ? sr_raw[1] : '0;

   // R7
   bad_mode_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (rd_a_data == '0 && rd_b_data == '0 && sr_rd_data == '0));

endmodule

// File: tb/sim_rbank_regfile.sv
`timescale 1ns/1ps
module sim_rbank_regfile;

   localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                          M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                          M_SYS = 5'b11111;

   logic        clk = 0, rst_n = 0;
   logic [4:0]  mode_i = M_USR, bk_mode = M_USR;
   logic [3:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0, bk_idx = 0;
   logic        wr_en = 0, sr_wr_en = 0, pc_ld_en = 0, bk_wr_en = 0, bk_sr_wr_en = 0;
   logic [31:0] wr_data = 0, sr_wr_data = 0, pc_ld_data = 0, bk_wr_data = 0, bk_sr_wr_data = 0;
   logic        illegal_o;
   logic [31:0] rd_a_data, rd_b_data, sr_rd_data, pc_o, bk_rd_data, bk_sr_rd_data;

   always #4 clk = ~clk;

   rbank_regfile #(.DW(32)) u0 (.*);

   typedef struct { int req; int sel; logic [31:0] exp; } item_t;
   item_t q[$];
   int errors = 0, checks = 0;
   bit done = 0;

   // reference model
   logic [31:0] m_sh [16];
   logic [31:0] m_fq [7];
   logic [31:0] m_bk [4][2];
   logic [31:0] m_sv [5];

   function automatic int bnk(logic [4:0] m);
      case (m)
         M_USR, M_SYS: return 0;
         M_FIQ: return 1;
         M_IRQ: return 2;
         M_SVC: return 3;
         M_ABT: return 4;
         M_UND: return 5;
         default: return 6;
      endcase
   endfunction

   function automatic logic [31:0] mread(logic [4:0] m, int i);
      int b = bnk(m);
      if (b == 6) return 0;
      if (i == 15) return m_sh[15];
      if (b == 1 && i >= 8) return m_fq[i-8];
      if (b >= 2 && i >= 13) return m_bk[b-2][i-13];
      return m_sh[i];
   endfunction

   function automatic void mwrite(logic [4:0] m, int i, logic [31:0] v);
      int b = bnk(m);
      if (b == 6) return;
      if (i == 15) m_sh[15] = v;
      else if (b == 1 && i >= 8) m_fq[i-8] = v;
      else if (b >= 2 && i >= 13) m_bk[b-2][i-13] = v;
      else m_sh[i] = v;
   endfunction

   function automatic logic [31:0] msr(logic [4:0] m);
      int b = bnk(m);
      return (b >= 1 && b <= 5) ? m_sv[b-1] : 32'h0;
   endfunction

   task automatic chk(int req, int sel, logic [31:0] v);
      item_t it;
      it.req = req; it.sel = sel; it.exp = v;
      q.push_back(it);
   endtask

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic gwrite(logic [4:0] m, int i, logic [31:0] v);
      mode_i = m; wr_idx = 4'(i); wr_data = v; wr_en = 1;
      cyc();
      wr_en = 0;
      mwrite(m, i, v);
   endtask

   task automatic swrite(logic [4:0] m, logic [31:0] v);
      mode_i = m; sr_wr_data = v; sr_wr_en = 1;
      cyc();
      sr_wr_en = 0;
      if (bnk(m) >= 1 && bnk(m) <= 5) m_sv[bnk(m)-1] = v;
   endtask

   task automatic look(int req, logic [4:0] m, int ia, int ib);
      mode_i = m; rd_a_idx = 4'(ia); rd_b_idx = 4'(ib);
      chk(req, 0, mread(m, ia));
      chk(req, 1, mread(m, ib));
      cyc();
   endtask

   // monitor: compares queued expectations away from the active edge
   always @(negedge clk) begin
      while (q.size() > 0) begin
         item_t it;
         logic [31:0] got;
         it = q.pop_front();
         case (it.sel)
            0: got = rd_a_data;
            1: got = rd_b_data;
            2: got = sr_rd_data;
            3: got = {31'b0, illegal_o};
            4: got = pc_o;
            5: got = bk_rd_data;
            default: got = bk_sr_rd_data;
         endcase
         checks++;
         if (got !== it.exp) begin
            errors++;
            $display("FAIL R%0d sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL R0 watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      foreach (m_sh[i]) m_sh[i] = 0;
      foreach (m_fq[i]) m_fq[i] = 0;
      foreach (m_sv[i]) m_sv[i] = 0;
      for (int a = 0; a < 4; a++) for (int b = 0; b < 2; b++) m_bk[a][b] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      cyc();

      // R10 reset state
      look(10, M_USR, 0, 14);
      look(10, M_FIQ, 9, 14);
      mode_i = M_SVC; chk(10, 2, 0); chk(10, 4, 0); cyc();
      // R1 valid code not flagged
      mode_i = M_USR; chk(1, 3, 0); cyc();

      for (int i = 0; i < 16; i++) gwrite(M_USR, i, 32'h1000_0000 + 32'(i));
      for (int i = 8; i < 15; i++) gwrite(M_FIQ, i, 32'hF000_0000 + 32'(i));
      // R3 shared low, private high
      look(3, M_FIQ, 3, 10);
      look(3, M_USR, 10, 14);
      look(3, M_FIQ, 7, 14);
      // R5 index 15 shared
      look(5, M_FIQ, 15, 15);

      // R4 small banks
      gwrite(M_IRQ, 13, 32'h2200_0013); gwrite(M_IRQ, 14, 32'h2200_0014);
      gwrite(M_SVC, 13, 32'h3300_0013); gwrite(M_SVC, 14, 32'h3300_0014);
      gwrite(M_ABT, 13, 32'h4400_0013); gwrite(M_ABT, 14, 32'h4400_0014);
      gwrite(M_UND, 13, 32'h5500_0013); gwrite(M_UND, 14, 32'h5500_0014);
      gwrite(M_IRQ, 12, 32'h2200_0012);
      look(4, M_IRQ, 13, 14);
      look(4, M_SVC, 13, 14);
      look(4, M_ABT, 13, 14);
      look(4, M_UND, 13, 14);
      look(4, M_USR, 12, 13);
      look(4, M_SVC, 8, 12);

      // R2 system equals user
      gwrite(M_SYS, 4, 32'h6600_0004);
      look(2, M_USR, 4, 13);
      look(2, M_SYS, 13, 14);

      // R6 saved status per mode
      swrite(M_FIQ, 32'hA000_0001); swrite(M_IRQ, 32'hA000_0002);
      swrite(M_SVC, 32'hA000_0003); swrite(M_ABT, 32'hA000_0004);
      swrite(M_UND, 32'hA000_0005);
      mode_i = M_FIQ; chk(6, 2, msr(M_FIQ)); cyc();
      mode_i = M_IRQ; chk(6, 2, msr(M_IRQ)); cyc();
      mode_i = M_SVC; chk(6, 2, msr(M_SVC)); cyc();
      mode_i = M_ABT; chk(6, 2, msr(M_ABT)); cyc();
      mode_i = M_UND; chk(6, 2, msr(M_UND)); cyc();
      // R2 user and system have no saved status
      swrite(M_USR, 32'hDEAD_0001);
      swrite(M_SYS, 32'hDEAD_0002);
      mode_i = M_USR; chk(2, 2, 0); cyc();
      mode_i = M_SYS; chk(2, 2, 0); cyc();
      for (int b = 0; b < 5; b++) begin
         bk_mode = (b == 0) ? M_FIQ : (b == 1) ? M_IRQ : (b == 2) ? M_SVC : (b == 3) ? M_ABT : M_UND;
         chk(2, 6, m_sv[b]); cyc();
      end

      // R1 and R7 invalid codes
      mode_i = 5'b10100; rd_a_idx = 1; rd_b_idx = 15;
      chk(1, 3, 1); chk(7, 0, 0); chk(7, 1, 0); chk(7, 2, 0); cyc();
      mode_i = 5'b00000; chk(1, 3, 1); cyc();
      mode_i = 5'b11110; chk(1, 3, 1); cyc();
      gwrite(5'b10100, 2, 32'hBAD0_0002);
      swrite(5'b10100, 32'hBAD0_0005);
      look(7, M_USR, 2, 15);
      mode_i = M_SVC; chk(7, 2, msr(M_SVC)); cyc();

      // R8 read during write returns old value
      mode_i = M_USR; rd_a_idx = 5; rd_b_idx = 5;
      wr_idx = 5; wr_data = 32'h7777_0005; wr_en = 1;
      chk(8, 0, mread(M_USR, 5));
      cyc();
      wr_en = 0; mwrite(M_USR, 5, 32'h7777_0005);
      chk(8, 0, mread(M_USR, 5)); cyc();

      // R5 load path beats a same-cycle write to index 15
      mode_i = M_USR; wr_idx = 15; wr_data = 32'h1111_1111; wr_en = 1;
      pc_ld_data = 32'h0000_0400; pc_ld_en = 1;
      cyc();
      wr_en = 0; pc_ld_en = 0; m_sh[15] = 32'h0000_0400;
      chk(5, 4, 32'h0000_0400); cyc();
      look(5, M_UND, 15, 14);

      // R9 banked port writes another mode's link and saved status
      mode_i = M_USR; bk_mode = M_IRQ; bk_idx = 14;
      bk_wr_data = 32'hC0DE_0014; bk_wr_en = 1;
      bk_sr_wr_data = 32'hC0DE_5A5A; bk_sr_wr_en = 1;
      cyc();
      bk_wr_en = 0; bk_sr_wr_en = 0;
      mwrite(M_IRQ, 14, 32'hC0DE_0014); m_sv[1] = 32'hC0DE_5A5A;
      chk(9, 5, 32'hC0DE_0014); chk(9, 6, 32'hC0DE_5A5A); cyc();
      look(9, M_USR, 14, 13);
      mode_i = M_IRQ; chk(9, 2, 32'hC0DE_5A5A); cyc();
      look(9, M_IRQ, 14, 13);
      // R9 banked saved-status write to user mode has no effect
      bk_mode = M_USR; bk_sr_wr_data = 32'hEEEE_EEEE; bk_sr_wr_en = 1;
      cyc();
      bk_sr_wr_en = 0;
      chk(9, 6, 0); cyc();
      bk_mode = M_IRQ; chk(9, 6, 32'hC0DE_5A5A); cyc();
      // R9 invalid banked mode reads zero
      bk_mode = 5'b01010; bk_idx = 3; chk(9, 5, 0); cyc();
      // R9 banked write wins a clash on the same cell
      mode_i = M_USR; wr_idx = 6; wr_data = 32'h0A0A_0006; wr_en = 1;
      bk_mode = M_SYS; bk_idx = 6; bk_wr_data = 32'h0B0B_0006; bk_wr_en = 1;
      cyc();
      wr_en = 0; bk_wr_en = 0; mwrite(M_USR, 6, 32'h0B0B_0006);
      look(9, M_USR, 6, 6);

      cyc();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule